// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI controller that only acts as bus master. Words come from the read port of a transmit FIFO, which shows the next word ahead and advances on a pop. Each word goes out on MOSI with its most significant bit first. The bits seen on MISO during the same burst are collected into a receive word, and that word is offered to the write port of a receive FIFO when the burst ends. The register file that holds the configuration, the FIFOs themselves, interrupts and DMA all sit outside this block.

Configuration arrives as static inputs:
- a burst length given as the bit count minus one;
- a linear prescale code and a power-of-two postscale code for the serial clock;
- clock phase and clock polarity;
- an idle clock level, kept separate from the polarity;
- the polarity of the single hardware chip select.

A transfer starts in one of two ways: on an exchange pulse, or on its own whenever the auto-start input is high and transmit data is waiting. Dropping the enable input holds the whole engine in reset.

The controller has five states:
- IDLE waits for a start.
- FETCH pops one word and loads it.
- LEAD is the first half of a bit, with SCLK at the polarity level.
- TRAIL is the second half of a bit, with SCLK inverted.
- DONE hands the received word over.

The transitions are:
- IDLE→FETCH on a start request with data present.
- FETCH→LEAD always.
- LEAD→TRAIL on a divider tick.
- TRAIL→LEAD on a tick before the last bit.
- TRAIL→DONE on a tick after the last bit.
- DONE→FETCH when more words are queued and the run continues.
- DONE→IDLE otherwise.
- Any state→IDLE while enable is low.

Top module: `spi_shift_master`

## Requirements
- R1: Each SCLK half period inside a burst lasts (prediv+1)·2^postdiv cycles of clk.
- R2: A burst carries burst_len+1 bits. Bit burst_len of tx_data goes out first. The received word is right-aligned in rx_data, and its unused upper bits are zero.
- R3: The leading edge is the SCLK transition away from the cpol level. With cpha=0, MISO is sampled on leading edges and MOSI changes on trailing edges. With cpha=1, MOSI changes on leading edges after the first bit, and MISO is sampled on trailing edges.
- R4: Outside a burst, SCLK equals idle_hi, whatever the value of cpol.
- R5: ss is at its active level, which is 1 when ss_active_hi=1 and 0 otherwise. It stays active from the fetch of the first word until the last word of a run completes, including the gap between back-to-back words. At all other times it is inactive.
- R6: An xch pulse with transmit data present starts a run. The run goes on while words remain. An xch pulse while the transmit FIFO is empty is ignored.
- R7: While auto_start is high, the engine starts and keeps going as long as transmit data exists, with no xch pulse.
- R8: While en is low, the engine is reset. From the next cycle on, ss is inactive, SCLK is at idle_hi and there are no pops. An interrupted word is never pushed.
- R9: xfer_done is high only when en is high, the transmit FIFO is empty and no word is being shifted.
- R10: At the end of each burst the word is pushed for one cycle if rx_full is low. If rx_full is high, the word is dropped and rx_overflow pulses for one cycle instead.
- R11: tx_pop is a one-cycle pulse, exactly one per word, and it is given only when tx_empty is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine and reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable; low holds it in reset |
| xch | input | 1 | Exchange start pulse |
| auto_start | input | 1 | Start whenever transmit data exists |
| burst_len | input | LEN_W | Bits per burst minus one |
| prediv | input | PRE_W | Linear prescale code (divide by code+1) |
| postdiv | input | POST_W | Power-of-two postscale code |
| cpha | input | 1 | Clock phase select |
| cpol | input | 1 | Clock polarity inside a burst |
| idle_hi | input | 1 | SCLK level between bursts |
| ss_active_hi | input | 1 | Chip select active high when set |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DATA_W | Head word of the transmit FIFO |
| tx_pop | output | 1 | Advance the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Write rx_data into the receive FIFO |
| rx_data | output | DATA_W | Received word, right-aligned |
| rx_overflow | output | 1 | Received word dropped because the FIFO was full |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss | output | 1 | Hardware chip select |
| xfer_done | output | 1 | Transmit FIFO empty and shifter idle |

## Verification
Two events can fall in the same cycle.

The first pair is the pop of the last queued word and the transfer-complete flag. The pop leaves tx_empty high while the shifter is still busy for a whole burst. The bench provokes this with a slow, 32-bit, single-word transfer, then judges it by requiring xfer_done to be low mid-burst even though the FIFO already reads empty.

The second pair is the end-of-burst hand-off and a full receive FIFO. The bench holds rx_full high across a burst and expects exactly one rx_overflow pulse and no rx_push. A serial slave model in the bench checks the MOSI bits, the MISO alignment and the SCLK half periods against each vector.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LEAD  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_DONE  = 3'd4
    } eng_state_t;
endpackage

// File: rtl/spi_clk_div.sv
// Two-stage divider: linear prescaler then power-of-two postscaler.
// tick pulses once every (prediv+1) * 2^postdiv cycles after clear drops.
module spi_clk_div #(
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [PRE_W-1:0]  prediv,
    input  logic [POST_W-1:0] postdiv,
    output logic              tick
);
    localparam int POST_CNT_W = (1 << POST_W) - 1;

    logic [PRE_W-1:0]      pre_cnt;
    logic [POST_CNT_W-1:0] post_cnt;
    logic [POST_CNT_W-1:0] post_lim;
    logic                  pre_wrap;

    always_comb begin
        post_lim = {POST_CNT_W{1'b1}} >> (POST_CNT_W - int'(postdiv));
        pre_wrap = (pre_cnt == prediv);
        tick     = pre_wrap && (post_cnt == post_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (clear) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else begin
            pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
            if (pre_wrap)
                post_cnt <= (post_cnt == post_lim) ? '0 : post_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_dp.sv
// Transmit and receive shift registers. The transmit word is left-aligned
// on load so the top bit of the burst drives MOSI first.
module spi_shift_dp #(
    parameter int W     = 32,
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             shift_en,
    input  logic             sample_en,
    input  logic             miso,
    input  logic [W-1:0]     tx_word,
    input  logic [CNT_W-1:0] nbits,
    output logic             mosi,
    output logic [W-1:0]     rx_word
);
    logic [W-1:0] tx_sh;
    logic [W-1:0] rx_sh;
    int           shamt;

    always_comb begin
        shamt = (int'(nbits) >= W) ? 0 : W - int'(nbits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (clear) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load)
                tx_sh <= tx_word << shamt;
            else if (shift_en)
                tx_sh <= {tx_sh[W-2:0], 1'b0};
            if (load)
                rx_sh <= '0;
            else if (sample_en)
                rx_sh <= {rx_sh[W-2:0], miso};
        end
    end

    assign mosi    = tx_sh[W-1];
    assign rx_word = rx_sh;
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 12,
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              xch,
    input  logic              auto_start,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [PRE_W-1:0]  prediv,
    input  logic [POST_W-1:0] postdiv,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              idle_hi,
    input  logic              ss_active_hi,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_overflow,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              ss,
    output logic              xfer_done
);
    localparam int CNT_W = LEN_W + 1;

    eng_state_t       state, nxt;
    logic [LEN_W-1:0] bit_cnt;
    logic             keep;
    logic             tick;
    logic             go;
    logic             last_bit;
    logic             in_bit;
    logic             lead_edge, trail_edge;
    logic             sample_en, shift_en, load;
    logic             ss_on;
    logic [CNT_W-1:0] nbits;

    assign nbits    = {1'b0, burst_len} + 1'b1;
    assign go       = (xch | auto_start) & ~tx_empty;
    assign last_bit = (bit_cnt == burst_len);
    assign in_bit   = (state == ST_LEAD) || (state == ST_TRAIL);

    // State register; a low enable holds the engine in reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (!en)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (go) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_TRAIL;
            ST_TRAIL: if (tick) nxt = last_bit ? ST_DONE : ST_LEAD;
            ST_DONE:  nxt = ((keep | auto_start) && !tx_empty) ? ST_FETCH : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Bit counter and run latch for exchange-pulse mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            keep    <= 1'b0;
        end else if (!en) begin
            bit_cnt <= '0;
            keep    <= 1'b0;
        end else begin
            if (state == ST_FETCH)
                bit_cnt <= '0;
            else if (state == ST_TRAIL && tick)
                bit_cnt <= bit_cnt + 1'b1;
            keep <= (state == ST_IDLE) ? (xch & ~tx_empty) : (keep | xch);
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        sclk        = idle_hi;
        ss_on       = 1'b1;
        tx_pop      = 1'b0;
        load        = 1'b0;
        rx_push     = 1'b0;
        rx_overflow = 1'b0;
        lead_edge   = 1'b0;
        trail_edge  = 1'b0;
        unique case (state)
            ST_IDLE:  ss_on = 1'b0;
            ST_FETCH: begin
                tx_pop = 1'b1;
                load   = 1'b1;
            end
            ST_LEAD: begin
                sclk      = cpol;
                lead_edge = tick;
            end
            ST_TRAIL: begin
                sclk       = ~cpol;
                trail_edge = tick;
            end
            ST_DONE: begin
                rx_push     = ~rx_full;
                rx_overflow = rx_full;
            end
            default: ss_on = 1'b0;
        endcase
        sample_en = cpha ? trail_edge : lead_edge;
        shift_en  = cpha ? (lead_edge && bit_cnt != '0) : trail_edge;
        ss        = ss_on ? ss_active_hi : ~ss_active_hi;
        xfer_done = en && (state == ST_IDLE) && tx_empty;
    end

    spi_clk_div #(
        .PRE_W  (PRE_W),
        .POST_W (POST_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!en || !in_bit),
        .prediv  (prediv),
        .postdiv (postdiv),
        .tick    (tick)
    );

    spi_shift_dp #(
        .W     (DATA_W),
        .CNT_W (CNT_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!en),
        .load      (load),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .tx_word   (tx_data),
        .nbits     (nbits),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic tx_empty,
    input logic tx_pop,
    input logic rx_full,
    input logic rx_push,
    input logic rx_overflow,
    input logic ss,
    input logic ss_active_hi,
    input logic sclk,
    input logic idle_hi,
    input logic xfer_done
);
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R11
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop); // R11
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R10
    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |=> !rx_overflow); // R10
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ss != ss_active_hi) && !tx_pop); // R8
    AST_DONE_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (ss != ss_active_hi) && (sclk == idle_hi)); // R9
endmodule

bind spi_shift_master spi_shift_master_chk u_chk (.*);

// File: tb/test_spi_shift_master.sv
`timescale 1ns/1ps
module test_spi_shift_master;
    localparam int W  = 32;
    localparam int LW = 12;

    typedef struct packed {
        logic        ph;
        logic        pol;
        logic [11:0] len;
        logic [3:0]  pre;
        logic [3:0]  post;
        logic [31:0] tx;
        logic [31:0] rx;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 12'd7,  4'd0, 4'd0, 32'h0000_00A5, 32'h0000_003C},
        '{1'b1, 1'b0, 12'd7,  4'd1, 4'd0, 32'h0000_0096, 32'h0000_005A},
        '{1'b0, 1'b1, 12'd15, 4'd0, 4'd1, 32'h0000_BEEF, 32'h0000_1234},
        '{1'b1, 1'b1, 12'd3,  4'd2, 4'd1, 32'h0000_0009, 32'h0000_0006},
        '{1'b0, 1'b0, 12'd31, 4'd0, 4'd0, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
        '{1'b1, 1'b1, 12'd0,  4'd3, 4'd2, 32'h0000_0001, 32'h0000_0001}
    };

    logic          clk = 0, rst_n = 0, en = 0, xch = 0, auto_start = 0;
    logic [LW-1:0] burst_len = 12'd7;
    logic [3:0]    prediv = 0, postdiv = 0;
    logic          cpha = 0, cpol = 0, idle_hi = 0, ss_active_hi = 0;
    logic          tx_empty, tx_pop, rx_full = 0, rx_push, rx_overflow;
    logic [W-1:0]  tx_data, rx_data;
    logic          miso, sclk, mosi, ss, xfer_done;

    always #5 clk = ~clk;

    spi_shift_master i_spi_shift_master (
        .clk(clk), .rst_n(rst_n), .en(en), .xch(xch), .auto_start(auto_start),
        .burst_len(burst_len), .prediv(prediv), .postdiv(postdiv),
        .cpha(cpha), .cpol(cpol), .idle_hi(idle_hi), .ss_active_hi(ss_active_hi),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .rx_overflow(rx_overflow), .miso(miso), .sclk(sclk), .mosi(mosi),
        .ss(ss), .xfer_done(xfer_done)
    );

    // Transmit FIFO model and receive capture
    logic [W-1:0] txq [0:7];
    int wr_ptr = 0, rd_ptr = 0, n_pop = 0, n_push = 0, n_ovf = 0;
    logic [W-1:0] rx_log [0:3];
    assign tx_empty = (wr_ptr == rd_ptr);
    assign tx_data  = txq[rd_ptr[2:0]];

    always @(posedge clk) begin
        if (tx_pop) begin
            rd_ptr <= rd_ptr + 1;
            n_pop  <= n_pop + 1;
        end
        if (rx_push) begin
            rx_log[n_push[1:0]] <= rx_data;
            n_push <= n_push + 1;
        end
        if (rx_overflow) n_ovf <= n_ovf + 1;
    end

    // Serial slave model
    logic [W-1:0] sword = '0, cap = '0;
    int  nb = 1, sk = 0, n_edges = 0, ss_bad = 0, hmin = 0, hmax = 0, n_ss_tog = 0;
    time last_t = 0;
    bit  mon_on = 0;

    assign miso = cpha ? ((sk == 0) ? 1'b0 : sword[nb-1-((sk-1)%nb)])
                       : sword[nb-1-(sk%nb)];

    always @(sclk) begin
        if (mon_on) begin
            int d;
            if (ss != ss_active_hi) ss_bad++;
            if (n_edges > 0) begin
                d = int'(($time - last_t) / 10);
                if (d < hmin) hmin = d;
                if (d > hmax) hmax = d;
            end
            last_t = $time;
            n_edges++;
            if (sclk != cpol) begin
                if (!cpha) cap = {cap[W-2:0], mosi};
                else sk++;
            end else begin
                if (cpha) cap = {cap[W-2:0], mosi};
                else sk++;
            end
        end
    end

    always @(ss) if (mon_on) n_ss_tog++;

    int  n_chk = 0, n_err = 0;
    bit  reported = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic push_tx(input logic [W-1:0] w);
        txq[wr_ptr[2:0]] = w;
        wr_ptr = wr_ptr + 1;
    endtask

    task automatic arm_slave(input int bits, input logic [W-1:0] sw);
        nb = bits; sword = sw; cap = '0; sk = 0; n_edges = 0;
        hmin = 1 << 30; hmax = 0; ss_bad = 0; n_ss_tog = 0;
    endtask

    function automatic longint mask_of(input int bits);
        return (bits >= 32) ? 64'hFFFF_FFFF : ((64'd1 << bits) - 1);
    endfunction

    task automatic run_vec(input vec_t v);
        int p0, h;
        mon_on = 0;
        @(negedge clk);
        cpha = v.ph; cpol = v.pol; idle_hi = v.pol; burst_len = v.len;
        prediv = v.pre; postdiv = v.post;
        repeat (3) @(negedge clk);
        arm_slave(int'(v.len) + 1, v.rx);
        h = (int'(v.pre) + 1) << v.post;
        p0 = n_push;
        push_tx(v.tx);
        mon_on = 1;
        xch = 1; @(negedge clk); xch = 0;
        for (int i = 0; i < 20000 && n_push == p0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        mon_on = 0;
        chk("R3 received word", longint'(rx_log[p0[1:0]]), longint'(v.rx) & mask_of(nb));
        chk("R3 slave saw MOSI", longint'(cap) & mask_of(nb), longint'(v.tx) & mask_of(nb));
        chk("R2 SCLK edge count", n_edges, 2 * nb);
        chk("R1 shortest half period", hmin, (nb > 0) ? h : 0);
        chk("R1 longest half period", hmax, h);
        chk("R5 ss active on edges", ss_bad, 0);
        chk("R4 SCLK idle after burst", sclk, idle_hi);
        chk("R9 done after burst", xfer_done, 1);
    endtask

    initial begin
        #1_500_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        int p0, q0, o0;
        en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // Reset state: R5 R4 R9 R11
        chk("R5 ss inactive after reset", ss, 1);
        chk("R4 SCLK idle after reset", sclk, 0);
        chk("R9 done after reset", xfer_done, 1);
        chk("R11 no pop after reset", tx_pop, 0);

        // R6: exchange pulse with empty FIFO is ignored
        q0 = n_pop;
        xch = 1; @(negedge clk); xch = 0;
        repeat (5) @(negedge clk);
        chk("R6 empty xch keeps ss off", ss, 1);
        chk("R6 empty xch no pop", n_pop - q0, 0);

        // Vector table walk: R1 R2 R3
        foreach (VECS[i]) run_vec(VECS[i]);

        // R4: idle level independent of polarity
        cpol = 0; idle_hi = 1;
        repeat (2) @(negedge clk);
        chk("R4 idle high with cpol 0", sclk, 1);
        idle_hi = 0;

        // R7 R5 R11: auto start, two words back to back, active-high select
        cpha = 0; cpol = 0; burst_len = 7; prediv = 0; postdiv = 0; ss_active_hi = 1;
        repeat (2) @(negedge clk);
        chk("R5 active-high ss idles low", ss, 0);
        arm_slave(8, 32'h81);
        p0 = n_push; q0 = n_pop;
        push_tx(32'h11); push_tx(32'hC3);
        mon_on = 1;
        auto_start = 1;
        for (int i = 0; i < 5000 && n_push < p0 + 2; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        mon_on = 0; auto_start = 0;
        chk("R7 two words pushed", n_push - p0, 2);
        chk("R11 one pop per word", n_pop - q0, 2);
        chk("R7 first word", rx_log[p0[1:0]], 32'h81);
        chk("R7 second word", rx_log[p0[1:0] + 2'd1], 32'h81);
        chk("R2 last word on MOSI", cap & 32'hFF, 32'hC3);
        chk("R5 ss held between words", n_ss_tog, 2);
        ss_active_hi = 0;
        repeat (2) @(negedge clk);

        // R10: full receive FIFO drops the word
        rx_full = 1;
        arm_slave(8, 32'h55);
        p0 = n_push; o0 = n_ovf;
        push_tx(32'h0F);
        xch = 1; @(negedge clk); xch = 0;
        for (int i = 0; i < 5000 && n_ovf == o0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 one overflow pulse", n_ovf - o0, 1);
        chk("R10 no push when full", n_push - p0, 0);
        rx_full = 0;

        // R9 R8: FIFO empty while shifting, then abort by enable
        burst_len = 31; prediv = 15; postdiv = 2;
        arm_slave(32, 32'h0);
        p0 = n_push;
        push_tx(32'h1234_5678);
        xch = 1; @(negedge clk); xch = 0;
        repeat (200) @(negedge clk);
        chk("R9 FIFO empty mid-burst", tx_empty, 1);
        chk("R9 not done mid-burst", xfer_done, 0);
        en = 0;
        @(negedge clk);
        chk("R8 ss off when disabled", ss, 1);
        chk("R8 SCLK idle when disabled", sclk, idle_hi);
        chk("R9 not done when disabled", xfer_done, 0);
        repeat (5000) @(negedge clk);
        chk("R8 aborted word not pushed", n_push - p0, 0);
        en = 1;
        @(negedge clk);
        chk("R9 done after re-enable", xfer_done, 1);

        report();
    end
endmodule